// File: doc/BRIEF.md
# Sector-Based Near-Vector Candidate Selector

This block feeds the cost-minimising search of a finite-set predictive current controller for a two-level inverter with four legs (three phases plus a neutral leg). From the signed α and β components of the reference voltage it finds which of six 60° sectors the reference lies in. It then streams the six active leg states that surround that sector, one per clock, so that the search only has to evaluate those states. Each streamed state has a small common-mode code: the number of legs switched high minus two, in units of a quarter of the DC-link voltage.

Active states alone keep the common-mode voltage within plus or minus a quarter of the DC link. A mode input can append one zero state, either all legs high or all legs low, as a seventh candidate. This trades a one-sided common-mode excursion of half the DC link for lower current ripple. The α and β components, the mode and the zero-state choice are captured when a start pulse is accepted. The sector index stays on its output until the next accepted start.

Top module: `sector_cand_sel`

## Requirements
- R1: Let A = α·2^13 and T = β·14189, where 14189 is √3·2^13 rounded. If −A ≤ T ≤ A (this includes the origin and the 330° edge), the sector output is 0, which is sector I.
- R2: Outside sector I the sector output follows these rules. β>0 with α≥0 gives 1. β>0 with α<0 gives 2 when T ≥ −A and 3 otherwise. β=0 gives 3. β<0 with α<0 gives 3 when T ≥ A and 4 otherwise. β<0 with α=0 gives 4, and β<0 with α>0 gives 5. So a point on an edge goes to the lower-numbered sector.
- R3: Number the hexagon of three-leg states k=0..5, with x,y,z high for k=0:100, 1:110, 2:010, 3:011, 4:001 and 5:101. For sector s, candidates 1 to 6 take their three-leg part from k=s, s, s−1, s−1, s+1 and s+1 (all modulo 6). Within each pair the neutral leg is high first and low second.
- R4: Each candidate is a 4-bit code. Bit 3 is leg x, bit 2 is leg y, bit 1 is leg z and bit 0 is the neutral leg. A bit of 1 means the leg is switched to the positive rail.
- R5: With with_zero low, exactly six candidates are issued, and cand_last is high only with the sixth.
- R6: With with_zero high, a seventh candidate follows the six. It is 4'hF when zero_hi is high and 4'h0 when it is low, and cand_last is high only with it.
- R7: cand_cmv is the number of 1 bits in cand_code minus 2, as 3-bit two's complement. This gives −1..+1 for active candidates and ±2 for zero states.
- R8: The first candidate is valid in the cycle after the clock edge that accepts go. The rest follow on consecutive cycles, and cand_valid is low whenever no stream is running.
- R9: A go that arrives while a stream runs and cand_last is low is ignored. The stream, the sector and the captured inputs stay unchanged.
- R10: A go that arrives in the cycle showing cand_last is accepted. The new stream's first candidate follows with no idle cycle.
- R11: After reset, cand_valid and cand_last are low and the sector output is 0.
- R12: The sector output changes only on an accepted go.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start strobe for one candidate stream |
| v_alpha | input | COORD_W | Signed α component of the reference |
| v_beta | input | COORD_W | Signed β component of the reference |
| with_zero | input | 1 | 1 appends a zero state as the seventh candidate |
| zero_hi | input | 1 | Zero state choice: 1 is all legs high, 0 is all legs low |
| cand_code | output | 4 | Candidate leg states (x,y,z,n from bit 3 down) |
| cand_cmv | output | 3 | Signed common-mode code of the candidate |
| cand_valid | output | 1 | Candidate on cand_code is valid |
| cand_last | output | 1 | Final candidate of the stream |
| sector | output | 3 | Sector of the captured reference, 0..5 for I..VI |

## Verification
The two functions that can fall in the same cycle are the end of a stream and the acceptance of the next start. The bench holds go high exactly while the reference model shows one remaining entry, so the last candidate and a new capture meet on one clock edge. It then expects the new first candidate in the next cycle with cand_valid never dropping. A second collision has go arrive mid-stream with a different reference. Here the comparison on every cycle demands that the stream, the sector and the captured zero-state choice stay as they were.

// File: rtl/sector_pkg.sv
package sector_pkg;

   localparam int NUM_SECT  = 6;
   localparam int NUM_ACT   = 6;
   localparam int IDX_W     = 3;
   localparam int SECT_W    = 3;

   typedef logic [3:0] leg_code_t;

   // Three-leg hexagon state k (x,y,z, 1 = positive rail): even k has one
   // leg high, odd k is the union of its two even neighbours.
   function automatic logic [2:0] ring_abc(input int unsigned k);
      int unsigned m;
      logic [2:0]  lo;
      logic [2:0]  hi;
      m  = k % NUM_SECT;
      lo = 3'b100 >> (m / 2);
      hi = 3'b100 >> (((m + 1) % NUM_SECT) / 2);
      return (m % 2 == 0) ? lo : (lo | hi);
   endfunction

   // Common-mode code in quarter-DC-link units: legs high minus two.
   function automatic logic signed [2:0] cmv_of(input leg_code_t c);
      int n_hi;
      n_hi = $countones(c);
      return 3'(n_hi - 2);
   endfunction

endpackage

// File: rtl/sector_detect.sv
module sector_detect #(
   parameter int COORD_W = 16,
   parameter int FRAC_W  = 13
) (
   input  logic signed [COORD_W-1:0] alpha,
   input  logic signed [COORD_W-1:0] beta,
   output logic [sector_pkg::SECT_W-1:0] sect
);

   localparam int ROOT3_Q = $rtoi(1.7320508075688772 * (2.0 ** FRAC_W) + 0.5);
   localparam int PROD_W  = COORD_W + FRAC_W + 3;

   generate
      if (FRAC_W < 4 || FRAC_W > 20) begin : g_bad_frac
         $error("sector_detect: FRAC_W out of range");
      end
   endgenerate

   logic signed [PROD_W-1:0] a_ext, b_ext, a_sc, a_neg, t_sc, root3_c;

   assign root3_c = PROD_W'(ROOT3_Q);
   assign a_ext   = {{(PROD_W-COORD_W){alpha[COORD_W-1]}}, alpha};
   assign b_ext   = {{(PROD_W-COORD_W){beta[COORD_W-1]}}, beta};
   assign a_sc    = a_ext <<< FRAC_W;
   assign a_neg   = -a_sc;
   assign t_sc    = b_ext * root3_c;

   logic in_first, b_pos, b_zero, a_neg_s, a_zero;
   assign in_first = (t_sc <= a_sc) && (t_sc >= a_neg);
   assign b_pos    = !beta[COORD_W-1] && (beta != '0);
   assign b_zero   = (beta == '0);
   assign a_neg_s  = alpha[COORD_W-1];
   assign a_zero   = (alpha == '0);

   always_comb begin
      if (in_first)        sect = 3'd0;
      else if (b_pos)      sect = !a_neg_s ? 3'd1 : ((t_sc >= a_neg) ? 3'd2 : 3'd3);
      else if (b_zero)     sect = 3'd3;
      else if (a_neg_s)    sect = (t_sc >= a_sc) ? 3'd3 : 3'd4;
      else if (a_zero)     sect = 3'd4;
      else                 sect = 3'd5;
   end

endmodule

// File: rtl/cand_map.sv
module cand_map
   import sector_pkg::*;
(
   input  logic [SECT_W-1:0] sect,
   input  logic [IDX_W-1:0]  idx,
   input  logic              zero_hi,
   output leg_code_t         code
);

   localparam int RING_N = 1 << SECT_W;

   logic [2:0] ring [RING_N];

   for (genvar g = 0; g < RING_N; g++) begin : g_ring
      if (g < NUM_SECT) begin : g_used
         assign ring[g] = ring_abc(g);
      end else begin : g_spare
         assign ring[g] = 3'b000;
      end
   end

   logic [SECT_W-1:0] pos;

   always_comb begin
      case (idx[2:1])
         2'd0:    pos = sect;
         2'd1:    pos = (sect == 3'd0) ? 3'(NUM_SECT - 1) : sect - 3'd1;
         default: pos = (sect == 3'(NUM_SECT - 1)) ? 3'd0 : sect + 3'd1;
      endcase
   end

   assign code = (idx == 3'(NUM_ACT)) ? {4{zero_hi}} : {ring[pos], ~idx[0]};

endmodule

// File: rtl/cand_seq.sv
module cand_seq
   import sector_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              with_zero,
   input  logic              zero_hi,
   input  logic [SECT_W-1:0] sect_in,
   output logic              busy,
   output logic              last,
   output logic [IDX_W-1:0]  idx,
   output logic [SECT_W-1:0] sect_q,
   output logic              zero_hi_q
);

   localparam logic [IDX_W-1:0] END_ACT  = IDX_W'(NUM_ACT - 1);
   localparam logic [IDX_W-1:0] END_ZERO = IDX_W'(NUM_ACT);

   logic zmode_q, accept;

   assign last   = busy && (idx == (zmode_q ? END_ZERO : END_ACT));
   assign accept = go && (!busy || last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         idx       <= '0;
         sect_q    <= '0;
         zmode_q   <= 1'b0;
         zero_hi_q <= 1'b0;
      end else if (accept) begin
         busy      <= 1'b1;
         idx       <= '0;
         sect_q    <= sect_in;
         zmode_q   <= with_zero;
         zero_hi_q <= zero_hi;
      end else if (last) begin
         busy      <= 1'b0;
         idx       <= '0;
      end else if (busy) begin
         idx       <= idx + 1'b1;
      end
   end

endmodule

// File: rtl/sector_cand_sel.sv
module sector_cand_sel
   import sector_pkg::*;
#(
   parameter int COORD_W = 16,
   parameter int FRAC_W  = 13
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      go,
   input  logic signed [COORD_W-1:0] v_alpha,
   input  logic signed [COORD_W-1:0] v_beta,
   input  logic                      with_zero,
   input  logic                      zero_hi,
   output logic [3:0]                cand_code,
   output logic signed [2:0]         cand_cmv,
   output logic                      cand_valid,
   output logic                      cand_last,
   output logic [2:0]                sector
);

   generate
      if (COORD_W < 4 || COORD_W > 32) begin : g_bad_coord
         $error("sector_cand_sel: COORD_W out of range");
      end
   endgenerate

   logic [SECT_W-1:0] sect_now, sect_q;
   logic [IDX_W-1:0]  idx;
   logic              busy, last, zhi_q;
   leg_code_t         code;

   sector_detect #(.COORD_W(COORD_W), .FRAC_W(FRAC_W)) u_det (
      .alpha (v_alpha),
      .beta  (v_beta),
      .sect  (sect_now)
   );

   cand_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .with_zero (with_zero),
      .zero_hi   (zero_hi),
      .sect_in   (sect_now),
      .busy      (busy),
      .last      (last),
      .idx       (idx),
      .sect_q    (sect_q),
      .zero_hi_q (zhi_q)
   );

   cand_map u_map (
      .sect    (sect_q),
      .idx     (idx),
      .zero_hi (zhi_q),
      .code    (code)
   );

   assign cand_code  = busy ? code : 4'h0;
   assign cand_cmv   = cmv_of(cand_code);
   assign cand_valid = busy;
   assign cand_last  = last;
   assign sector     = sect_q;

endmodule

// File: rtl/sector_cand_sel_chk.sv
module sector_cand_sel_chk #(
   parameter int COORD_W = 16
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      go,
   input logic signed [COORD_W-1:0] v_alpha,
   input logic signed [COORD_W-1:0] v_beta,
   input logic                      with_zero,
   input logic                      zero_hi,
   input logic [3:0]                cand_code,
   input logic signed [2:0]         cand_cmv,
   input logic                      cand_valid,
   input logic                      cand_last,
   input logic [2:0]                sector
);

   // R8
   accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && (!cand_valid || cand_last)) |=> cand_valid);

   // R9
   stream_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid && !cand_last) |=> cand_valid);

   // R5
   last_in_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cand_last |-> cand_valid);

   // R7
   cmv_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid && cand_code != 4'hF && cand_code != 4'h0) |->
      (cand_cmv >= -3'sd1 && cand_cmv <= 3'sd1));

   // R6
   zero_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid && (cand_code == 4'hF || cand_code == 4'h0)) |-> cand_last);

   // R12
   sector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(go && (!cand_valid || cand_last)) |=> $stable(sector));

   // R2
   sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sector <= 3'd5);

endmodule

bind sector_cand_sel sector_cand_sel_chk #(.COORD_W(COORD_W)) u_chk (.*);

// File: tb/sim_sector_cand_sel.sv
module sim_sector_cand_sel;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               go = 1'b0;
   logic signed [15:0] v_alpha = '0;
   logic signed [15:0] v_beta = '0;
   logic               with_zero = 1'b0;
   logic               zero_hi = 1'b0;
   logic [3:0]         cand_code;
   logic signed [2:0]  cand_cmv;
   logic               cand_valid;
   logic               cand_last;
   logic [2:0]         sector;

   int  checks = 0;
   int  fails = 0;
   bit  done = 1'b0;
   int  exp_sec = 0;
   logic [7:0] q[$];   // {last, cmv[2:0], code[3:0]}

   always #5 clk = ~clk;

   sector_cand_sel u0 (.*);

   function automatic void check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endfunction

   // Sector rule from R1 and R2.
   function automatic int ref_sector(int a, int b);
      longint la, lt;
      la = longint'(a) * 8192;
      lt = longint'(b) * 14189;
      if (lt <= la && lt >= -la) return 0;
      if (b > 0)  return (a >= 0) ? 1 : ((lt >= -la) ? 2 : 3);
      if (b == 0) return 3;
      if (a < 0)  return (lt >= la) ? 3 : 4;
      return (a == 0) ? 4 : 5;
   endfunction

   // Candidate rule from R3, R4 and R6: legs high by hexagon position.
   function automatic logic [3:0] ref_cand(int s, int j, bit zh);
      int c;
      bit x, y, z;
      if (j == 6) return zh ? 4'hF : 4'h0;
      c = (j < 2) ? s : ((j < 4) ? (s + 5) % 6 : (s + 1) % 6);
      x = (c == 5 || c == 0 || c == 1);
      y = (c >= 1 && c <= 3);
      z = (c >= 3 && c <= 5);
      return {x, y, z, (j % 2 == 0)};
   endfunction

   // Reference model: update the expected stream on each clock edge.
   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         exp_sec = 0;
      end else if (go && q.size() <= 1) begin
         int n;
         q.delete();
         exp_sec = ref_sector(int'(v_alpha), int'(v_beta));
         n = with_zero ? 7 : 6;
         for (int j = 0; j < n; j++) begin
            logic [3:0] c;
            int ones;
            c = ref_cand(exp_sec, j, zero_hi);
            ones = int'(c[0]) + int'(c[1]) + int'(c[2]) + int'(c[3]);
            q.push_back({(j == n - 1), 3'(ones - 2), c});
         end
      end else if (q.size() > 0) begin
         void'(q.pop_front());
      end
   end

   // Compare on every cycle, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cand_valid == (q.size() != 0), "R8 valid", int'(cand_valid), int'(q.size() != 0));
         if (q.size() != 0 && cand_valid) begin
            check(cand_code == q[0][3:0], "R3/R4 code", int'(cand_code), int'(q[0][3:0]));
            check(cand_cmv == $signed(q[0][6:4]), "R7 cmv", int'(cand_cmv), int'($signed(q[0][6:4])));
            check(cand_last == q[0][7], "R5/R6 last", int'(cand_last), int'(q[0][7]));
         end
         check(int'(sector) == exp_sec, "R1/R2/R12 sector", int'(sector), exp_sec);
      end
   end

   task automatic fire(input int a, input int b, input bit wz, input bit zh);
      v_alpha   = 16'(a);
      v_beta    = 16'(b);
      with_zero = wz;
      zero_hi   = zh;
      go        = 1'b1;
      @(negedge clk);
      go        = 1'b0;
   endtask

   task automatic drain;
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      $display("FAIL watchdog expired");
      fails++;
      checks++;
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(cand_valid == 1'b0 && cand_last == 1'b0, "R11 idle after reset", int'(cand_valid), 0);
      check(sector == 3'd0, "R11 sector after reset", int'(sector), 0);

      // R4 first candidate of sector I: x high, y,z low, neutral high
      fire(1000, 0, 1'b0, 1'b0);
      check(cand_code == 4'b1001, "R4 first code sector I", int'(cand_code), 9);
      drain;

      // R1 edges and origin, R2 edges to lower-numbered sector
      fire(0, 0, 1'b0, 1'b0);          drain;   // R1 origin
      fire(14189, 8192, 1'b0, 1'b0);   drain;   // R1 30 deg edge
      fire(14189, -8192, 1'b1, 1'b1);  drain;   // R1 330 deg edge
      fire(0, 100, 1'b0, 1'b0);        drain;   // R2 90 deg edge
      fire(-14189, 8192, 1'b1, 1'b0);  drain;   // R2 150 deg edge
      fire(-100, 0, 1'b0, 1'b0);       drain;   // R2 180 deg
      fire(-14189, -8192, 1'b0, 1'b0); drain;   // R2 210 deg edge
      fire(0, -100, 1'b1, 1'b1);       drain;   // R2 270 deg edge
      fire(-32768, -32768, 1'b0, 1'b0); drain;  // R2 extreme corner
      fire(32767, -32768, 1'b1, 1'b0); drain;   // R2 extreme corner

      // R6 zero state value and common-mode code
      fire(500, 866, 1'b1, 1'b1);
      while (q.size() != 1) @(negedge clk);
      check(cand_code == 4'hF && cand_cmv == 3'sd2, "R6 all-high zero", int'(cand_code), 15);
      drain;

      // R9 go mid-stream with another reference is ignored
      fire(1000, 0, 1'b0, 1'b0);
      @(negedge clk);
      fire(-1000, 0, 1'b1, 1'b1);
      drain;
      check(sector == 3'd0, "R9 sector kept", int'(sector), 0);

      // R10 go together with last: seamless restart
      fire(500, 866, 1'b1, 1'b1);
      while (q.size() != 1) @(negedge clk);
      check(cand_last == 1'b1, "R10 last before restart", int'(cand_last), 1);
      fire(-500, -866, 1'b0, 1'b0);
      check(cand_valid == 1'b1 && sector == 3'd4, "R10 restart no gap", int'(sector), 4);
      while (q.size() != 1) @(negedge clk);
      fire(500, -866, 1'b1, 1'b0);
      drain;

      // Sweep around the circle in both modes
      for (int k = 0; k < 52; k++) begin
         real ang;
         ang = real'(k) * 7.0 * 3.14159265358979 / 180.0;
         fire($rtoi(20000.0 * $cos(ang)), $rtoi(20000.0 * $sin(ang)), k[0], k[1]);
         drain;
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule